// File: doc/BRIEF.md
# Linked Command Descriptor DMA Engine

This block is a single-channel DMA engine driven by command descriptors held in memory. Software places a list of descriptors in memory, loads the address of the first one through a kick strobe, and grants work by raising a semaphore count. Each descriptor takes four kinds of word. Word 0 is the address of the next descriptor. Word 1 holds a control halfword in bits 15:0 and a byte count in bits 31:16. Word 2 is the buffer address. From word 3 onward come zero to fifteen programmed-I/O words, which the engine hands to the peripheral's register port.

For each descriptor the engine reads the three header words in order, then the PIO words, then runs the data phase. The data phase either moves nothing, moves peripheral data into memory, or moves memory data out to the peripheral. It then waits for an end acknowledge if the descriptor asks for one and completes. At completion it can pulse an interrupt, take one from the semaphore, and follow the next pointer. A next pointer that leads back to an earlier descriptor forms a ring, and the semaphore count limits how many descriptors of the ring run. The engine only leaves its idle state while the semaphore is nonzero. Memory uses a word-wide request/acknowledge port with one access outstanding at a time.

Top module: `cmd_chain_dma`

## Requirements
- R1: While the semaphore count is 0 the engine stays idle and issues no memory request, even with a descriptor pending. The first sem_inc pulse starts it. The engine also checks the semaphore before each chained descriptor.
- R2: A descriptor at address A is read at A, A+4 and A+8, then its PIO words at A+12 upward. The PIO word count is in control bits 15:12. Each PIO word appears as one pio_we pulse with pio_idx counting 0,1,2,... and all PIO words come before any data-phase access.
- R3: Command code 2 in control bits 1:0 reads ceil(bytes/4) words from the buffer address upward and hands each one in order to the peripheral over per_tx_valid/per_tx_ready.
- R4: Command code 1 takes ceil(bytes/4) words from per_rx_valid/per_rx_ready and writes them to the buffer address upward.
- R5: Command code 0 makes no data-phase memory access and no peripheral data transfer. A byte count of 0 under code 1 or 2 does the same.
- R6: At completion, control bit 3 gives a one-cycle irq pulse and control bit 6 takes exactly one from the semaphore.
- R7: With control bit 2 set, the engine fetches the next descriptor from the next pointer. A ring of descriptors, each with bits 2, 3 and 6 set, runs exactly as many descriptors as the semaphore count granted, then resumes in ring order when more is granted.
- R8: With control bit 7 set, completion (irq, semaphore take, chaining) waits until per_end is seen.
- R9: per_term during a peripheral data handshake ends the data phase only if control bit 9 is set. If control bit 8 is also set, the engine raises term_err, drops the chain and gives no irq and no semaphore take. If bit 8 is clear, the descriptor completes normally.
- R10: Command code 3, a byte count above 0xFF00, or mem_err on any access raises bus_err and drops the chain with no irq and no semaphore take. A count of exactly 0xFF00 is accepted.
- R11: After reset the engine is idle with a semaphore count of 0, both error flags low and no memory request. A kick clears both error flags.
- R12: mem_req holds with a stable address until mem_ack. per_tx_valid holds with stable data until per_tx_ready, unless per_term is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kick | input | 1 | Load first descriptor address (taken while idle) |
| kick_addr | input | AW | Address of first descriptor |
| sem_inc | input | 1 | Add one to the semaphore |
| sem_count | output | SEM_W | Current semaphore count |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Access failed (with mem_ack) |
| pio_we | output | 1 | PIO register write strobe |
| pio_idx | output | 4 | PIO word index |
| pio_data | output | 32 | PIO word |
| per_tx_valid | output | 1 | Word for the peripheral is valid |
| per_tx_data | output | 32 | Word for the peripheral |
| per_tx_ready | input | 1 | Peripheral takes the word |
| per_rx_valid | input | 1 | Peripheral offers a word |
| per_rx_data | input | 32 | Word from the peripheral |
| per_rx_ready | output | 1 | Engine takes the word |
| per_end | input | 1 | End-of-transfer acknowledge |
| per_term | input | 1 | Terminate request |
| busy | output | 1 | Engine is working on a descriptor |
| irq | output | 1 | Completion pulse |
| bus_err | output | 1 | Sticky bus or command error |
| term_err | output | 1 | Sticky termination error |

## Verification
The hardest case to reach from the ports is a terminate that lands inside the data phase, since a normal peripheral finishes the handshake before the terminate can matter. The bench holds per_tx_ready low so the engine stays in the transmit handshake, waits until busy shows it is stuck there, and then pulses per_term. It does this once with the halt bit set and once without. A second hard case is a ring that never ends on its own. The bench grants an exact semaphore count and counts irq pulses, then grants one more and checks which descriptor the engine fetches first.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;

    localparam int DW      = 32;
    localparam int BC_W    = 16;
    localparam int WCNT_W  = BC_W - 1;
    localparam logic [BC_W-1:0] MAX_BYTES = 16'hFF00;

    localparam logic [1:0] CMD_NONE     = 2'd0;
    localparam logic [1:0] CMD_TO_MEM   = 2'd1;
    localparam logic [1:0] CMD_FROM_MEM = 2'd2;
    localparam logic [1:0] CMD_SENSE    = 2'd3;

    typedef struct packed {
        logic [3:0] pio_cnt;
        logic       flush;
        logic       halt_term;
        logic       wait_end;
        logic       dec_sem;
        logic       irq;
        logic       chain;
        logic [1:0] cmd;
    } ctrl_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_NEXT,
        ST_HDR_CTRL,
        ST_HDR_BUF,
        ST_PIO_RD,
        ST_MEM_RD,
        ST_PER_TX,
        ST_PER_RX,
        ST_MEM_WR,
        ST_WAIT_END
    } state_e;

endpackage

// File: rtl/cmd_chain_decode.sv
module cmd_chain_decode
    import cmd_chain_pkg::*;
(
    input  logic [DW-1:0]     word,
    output ctrl_t             ctl,
    output logic [WCNT_W-1:0] words,
    output logic              bad
);
    logic [BC_W-1:0] bytes;
    logic [BC_W:0]   rounded;
    logic            unused_bits;

    assign bytes   = word[31:16];
    assign rounded = {1'b0, bytes} + (BC_W+1)'(3);
    assign words   = rounded[BC_W:2];

    always_comb begin
        ctl.cmd       = word[1:0];
        ctl.chain     = word[2];
        ctl.irq       = word[3];
        ctl.dec_sem   = word[6];
        ctl.wait_end  = word[7];
        ctl.halt_term = word[8];
        ctl.flush     = word[9];
        ctl.pio_cnt   = word[15:12];
    end

    assign bad = (word[1:0] == CMD_SENSE) || (bytes > MAX_BYTES);

    assign unused_bits = ^{word[11:10], word[5:4]};
endmodule

// File: rtl/cmd_chain_sem.sv
module cmd_chain_sem #(
    parameter int SEM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [SEM_W-1:0] count,
    output logic             nonzero
);
    localparam logic [SEM_W-1:0] SEM_MAX = '1;

    logic [SEM_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != SEM_MAX) begin
            cnt_d = cnt_q + SEM_W'(1);
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_d = cnt_q - SEM_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count   = cnt_q;
    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/cmd_chain_ctl.sv
module cmd_chain_ctl
    import cmd_chain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic [AW-1:0] kick_addr,
    input  logic          sem_nz,
    output logic          sem_dec,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          pio_we,
    output logic [3:0]    pio_idx,
    output logic [DW-1:0] pio_data,
    output logic          per_tx_valid,
    output logic [DW-1:0] per_tx_data,
    input  logic          per_tx_ready,
    input  logic          per_rx_valid,
    input  logic [DW-1:0] per_rx_data,
    output logic          per_rx_ready,
    input  logic          per_end,
    input  logic          per_term,
    output logic          busy,
    output logic          irq,
    output logic          bus_err,
    output logic          term_err
);
    typedef struct packed {
        state_e            st;
        logic [AW-1:0]     desc;
        logic [AW-1:0]     nxt;
        logic [AW-1:0]     bufp;
        ctrl_t             ctl;
        logic [WCNT_W-1:0] left;
        logic [3:0]        pio_i;
        logic [DW-1:0]     hold;
        logic              pending;
        logic              pio_we;
        logic [3:0]        pio_idx;
        logic [DW-1:0]     pio_data;
        logic              irq;
        logic              bus_err;
        logic              term_err;
    } regs_t;

    regs_t r_d, r_q;

    ctrl_t             dec_ctl;
    logic [WCNT_W-1:0] dec_words;
    logic              dec_bad;
    state_e            data_st;

    cmd_chain_decode u_dec (
        .word  (mem_rdata),
        .ctl   (dec_ctl),
        .words (dec_words),
        .bad   (dec_bad)
    );

    // first state after the header and PIO words
    always_comb begin
        data_st = ST_WAIT_END;
        if (r_q.left != '0) begin
            if (r_q.ctl.cmd == CMD_FROM_MEM)    data_st = ST_MEM_RD;
            else if (r_q.ctl.cmd == CMD_TO_MEM) data_st = ST_PER_RX;
        end
    end

    always_comb begin
        r_d          = r_q;
        r_d.irq      = 1'b0;
        r_d.pio_we   = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = r_q.desc;
        mem_wdata    = r_q.hold;
        per_tx_valid = 1'b0;
        per_rx_ready = 1'b0;
        sem_dec      = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (kick) begin
                    r_d.desc     = kick_addr;
                    r_d.pending  = 1'b1;
                    r_d.bus_err  = 1'b0;
                    r_d.term_err = 1'b0;
                end else if (r_q.pending && sem_nz) begin
                    r_d.st = ST_HDR_NEXT;
                end
            end
            ST_HDR_NEXT: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.nxt = mem_rdata;
                    r_d.st  = ST_HDR_CTRL;
                end
            end
            ST_HDR_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + AW'(4);
                if (mem_ack) begin
                    r_d.ctl  = dec_ctl;
                    r_d.left = dec_words;
                    r_d.st   = ST_HDR_BUF;
                    if (dec_bad) begin
                        r_d.bus_err = 1'b1;
                        r_d.pending = 1'b0;
                        r_d.st      = ST_IDLE;
                    end
                end
            end
            ST_HDR_BUF: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + AW'(8);
                if (mem_ack) begin
                    r_d.bufp  = mem_rdata;
                    r_d.pio_i = '0;
                    r_d.st    = (r_q.ctl.pio_cnt != '0) ? ST_PIO_RD : data_st;
                end
            end
            ST_PIO_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + AW'(12) + AW'({r_q.pio_i, 2'b00});
                if (mem_ack) begin
                    r_d.pio_we   = 1'b1;
                    r_d.pio_idx  = r_q.pio_i;
                    r_d.pio_data = mem_rdata;
                    r_d.pio_i    = r_q.pio_i + 4'd1;
                    if (r_q.pio_i == r_q.ctl.pio_cnt - 4'd1) r_d.st = data_st;
                end
            end
            ST_MEM_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.bufp;
                if (mem_ack) begin
                    r_d.hold = mem_rdata;
                    r_d.st   = ST_PER_TX;
                end
            end
            ST_PER_TX: begin
                per_tx_valid = 1'b1;
                if (per_term && r_q.ctl.flush) begin
                    if (r_q.ctl.halt_term) begin
                        r_d.term_err = 1'b1;
                        r_d.pending  = 1'b0;
                        r_d.st       = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT_END;
                    end
                end else if (per_tx_ready) begin
                    r_d.left = r_q.left - WCNT_W'(1);
                    r_d.bufp = r_q.bufp + AW'(4);
                    r_d.st   = (r_q.left == WCNT_W'(1)) ? ST_WAIT_END : ST_MEM_RD;
                end
            end
            ST_PER_RX: begin
                per_rx_ready = !(per_term && r_q.ctl.flush);
                if (per_term && r_q.ctl.flush) begin
                    if (r_q.ctl.halt_term) begin
                        r_d.term_err = 1'b1;
                        r_d.pending  = 1'b0;
                        r_d.st       = ST_IDLE;
                    end else begin
                        r_d.st = ST_WAIT_END;
                    end
                end else if (per_rx_valid) begin
                    r_d.hold = per_rx_data;
                    r_d.st   = ST_MEM_WR;
                end
            end
            ST_MEM_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = r_q.bufp;
                if (mem_ack) begin
                    r_d.left = r_q.left - WCNT_W'(1);
                    r_d.bufp = r_q.bufp + AW'(4);
                    r_d.st   = (r_q.left == WCNT_W'(1)) ? ST_WAIT_END : ST_PER_RX;
                end
            end
            ST_WAIT_END: begin
                if (!r_q.ctl.wait_end || per_end) begin
                    r_d.irq     = r_q.ctl.irq;
                    sem_dec     = r_q.ctl.dec_sem;
                    r_d.pending = r_q.ctl.chain;
                    r_d.desc    = r_q.nxt;
                    r_d.st      = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // any failed memory access drops the chain
        if (mem_req && mem_ack && mem_err) begin
            r_d.bus_err = 1'b1;
            r_d.pending = 1'b0;
            r_d.pio_we  = 1'b0;
            r_d.st      = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign irq         = r_q.irq;
    assign bus_err     = r_q.bus_err;
    assign term_err    = r_q.term_err;
    assign pio_we      = r_q.pio_we;
    assign pio_idx     = r_q.pio_idx;
    assign pio_data    = r_q.pio_data;
    assign per_tx_data = r_q.hold;
endmodule

// File: rtl/cmd_chain_dma.sv
module cmd_chain_dma
    import cmd_chain_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SEM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic [AW-1:0]    kick_addr,
    input  logic             sem_inc,
    output logic [SEM_W-1:0] sem_count,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             pio_we,
    output logic [3:0]       pio_idx,
    output logic [31:0]      pio_data,
    output logic             per_tx_valid,
    output logic [31:0]      per_tx_data,
    input  logic             per_tx_ready,
    input  logic             per_rx_valid,
    input  logic [31:0]      per_rx_data,
    output logic             per_rx_ready,
    input  logic             per_end,
    input  logic             per_term,
    output logic             busy,
    output logic             irq,
    output logic             bus_err,
    output logic             term_err
);
    logic sem_dec;
    logic sem_nz;

    cmd_chain_sem #(.SEM_W(SEM_W)) u_sem (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (sem_inc),
        .dec     (sem_dec),
        .count   (sem_count),
        .nonzero (sem_nz)
    );

    cmd_chain_ctl #(.AW(AW)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .kick         (kick),
        .kick_addr    (kick_addr),
        .sem_nz       (sem_nz),
        .sem_dec      (sem_dec),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .mem_err      (mem_err),
        .pio_we       (pio_we),
        .pio_idx      (pio_idx),
        .pio_data     (pio_data),
        .per_tx_valid (per_tx_valid),
        .per_tx_data  (per_tx_data),
        .per_tx_ready (per_tx_ready),
        .per_rx_valid (per_rx_valid),
        .per_rx_data  (per_rx_data),
        .per_rx_ready (per_rx_ready),
        .per_end      (per_end),
        .per_term     (per_term),
        .busy         (busy),
        .irq          (irq),
        .bus_err      (bus_err),
        .term_err     (term_err)
    );
endmodule

// File: rtl/cmd_chain_chk.sv
module cmd_chain_chk #(
    parameter int AW    = 32,
    parameter int SEM_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [SEM_W-1:0] sem_count,
    input logic             irq,
    input logic             bus_err,
    input logic             term_err,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic             per_tx_valid,
    input logic             per_tx_ready,
    input logic [31:0]      per_tx_data,
    input logic             per_term
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1

    AST_START_NEEDS_SEM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sem_count) != '0); // R1

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_err) |-> (!busy && !irq)); // R9

    AST_BUSERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> (!busy && !irq)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_tx_valid && !per_tx_ready && !per_term) |=> (per_tx_valid && $stable(per_tx_data))); // R12
endmodule

bind cmd_chain_dma cmd_chain_chk #(.AW(AW), .SEM_W(SEM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .sem_count    (sem_count),
    .irq          (irq),
    .bus_err      (bus_err),
    .term_err     (term_err),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_addr     (mem_addr),
    .per_tx_valid (per_tx_valid),
    .per_tx_ready (per_tx_ready),
    .per_tx_data  (per_tx_data),
    .per_term     (per_term)
);

// File: tb/cmd_chain_dma_tb.sv
module cmd_chain_dma_tb_top;
    localparam int F_CH = 4, F_IRQ = 8, F_DS = 64, F_WE = 128, F_HT = 256, F_FL = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        kick = 1'b0;
    logic [31:0] kick_addr = '0;
    logic        sem_inc = 1'b0;
    logic [7:0]  sem_count;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;
    logic        pio_we;
    logic [3:0]  pio_idx;
    logic [31:0] pio_data;
    logic        per_tx_valid;
    logic [31:0] per_tx_data;
    logic        tx_rdy = 1'b1;
    logic        per_rx_ready;
    logic [31:0] per_rx_data;
    logic        per_end = 1'b0, per_term = 1'b0;
    logic        busy, irq, bus_err, term_err;

    cmd_chain_dma dut_i (
        .clk(clk), .rst_n(rst_n), .kick(kick), .kick_addr(kick_addr),
        .sem_inc(sem_inc), .sem_count(sem_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .pio_we(pio_we), .pio_idx(pio_idx), .pio_data(pio_data),
        .per_tx_valid(per_tx_valid), .per_tx_data(per_tx_data), .per_tx_ready(tx_rdy),
        .per_rx_valid(1'b1), .per_rx_data(per_rx_data), .per_rx_ready(per_rx_ready),
        .per_end(per_end), .per_term(per_term),
        .busy(busy), .irq(irq), .bus_err(bus_err), .term_err(term_err)
    );

    // memory model: one access at a time, acknowledged the cycle after the request
    logic [31:0] mem [256];
    logic        tb_wr = 1'b0;
    logic [31:0] tb_wa = '0, tb_wd = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (tb_wr) mem[tb_wa[9:2]] <= tb_wd;
        else if (mem_req && !mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            mem_err   <= (mem_addr == err_addr);
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0;
        end
    end

    // observation logs
    logic        clr = 1'b0;
    int          acc_cnt = 0, tx_cnt = 0, pio_cnt = 0, irq_cnt = 0, rx_cnt = 0;
    logic [31:0] acc_log [32];
    logic [31:0] tx_log [16];
    logic [31:0] pio_log [16];
    logic [3:0]  pio_ix [16];

    assign per_rx_data = 32'hA000_0000 + 32'(rx_cnt);

    always @(posedge clk) begin
        if (clr) begin
            acc_cnt <= 0; tx_cnt <= 0; pio_cnt <= 0; irq_cnt <= 0; rx_cnt <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                if (acc_cnt < 32) acc_log[acc_cnt] <= mem_addr;
                acc_cnt <= acc_cnt + 1;
            end
            if (per_tx_valid && tx_rdy) begin
                if (tx_cnt < 16) tx_log[tx_cnt] <= per_tx_data;
                tx_cnt <= tx_cnt + 1;
            end
            if (pio_we) begin
                if (pio_cnt < 16) begin
                    pio_log[pio_cnt] <= pio_data;
                    pio_ix[pio_cnt]  <= pio_idx;
                end
                pio_cnt <= pio_cnt + 1;
            end
            if (per_rx_ready) rx_cnt <= rx_cnt + 1;
            if (irq) irq_cnt <= irq_cnt + 1;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        tb_wr = 1'b1; tb_wa = a; tb_wd = d;
        @(negedge clk);
        tb_wr = 1'b0;
    endtask

    task automatic wdesc(input logic [31:0] base, input logic [31:0] nxt, input int cmd,
                         input int flags, input int npio, input logic [15:0] bytes,
                         input logic [31:0] bufa);
        put(base, nxt);
        put(base + 4, {bytes, 16'(cmd | flags | (npio << 12))});
        put(base + 8, bufa);
    endtask

    task automatic clear_logs();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic do_kick(input logic [31:0] a);
        kick = 1'b1; kick_addr = a;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic grant(input int n);
        for (int i = 0; i < n; i++) begin
            sem_inc = 1'b1;
            @(negedge clk);
        end
        sem_inc = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int i = 0; i < 3000 && quiet < 6; i++) begin
            @(negedge clk);
            if (!busy) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic t_reset();
        eq("R11 busy after reset", busy, 0);
        eq("R11 semaphore after reset", sem_count, 0);
        eq("R11 bus_err after reset", bus_err, 0);
        eq("R11 term_err after reset", term_err, 0);
        eq("R11 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_gate();
        wdesc(32'h100, 32'h0, 0, F_IRQ | F_DS, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h100);
        repeat (20) @(negedge clk);
        eq("R1 no access with semaphore 0", acc_cnt, 0);
        eq("R1 idle with semaphore 0", busy, 0);
        grant(1);
        wait_idle();
        eq("R1 runs after grant", acc_cnt, 3);
        eq("R6 irq pulse count", irq_cnt, 1);
        eq("R6 semaphore taken", sem_count, 0);
    endtask

    task automatic t_pio();
        wdesc(32'h200, 32'h0, 0, F_IRQ | F_DS, 3, 16'd0, 32'h0);
        put(32'h20C, 32'h11); put(32'h210, 32'h22); put(32'h214, 32'h33);
        clear_logs();
        do_kick(32'h200);
        grant(1);
        wait_idle();
        eq("R2 pio write count", pio_cnt, 3);
        for (int k = 0; k < 3; k++) begin
            eq("R2 pio index", pio_ix[k], k);
            eq("R2 pio data", pio_log[k], 32'h11 * (k + 1));
        end
        eq("R5 no data access for code 0", acc_cnt, 6);
        for (int k = 0; k < 6; k++) eq("R2 fetch order", acc_log[k], 32'h200 + 4 * k);
        eq("R5 no peripheral transfer", tx_cnt, 0);
    endtask

    task automatic t_read();
        put(32'h300, 32'hC0C0_0000); put(32'h304, 32'hC0C0_0001); put(32'h308, 32'hC0C0_0002);
        wdesc(32'h040, 32'h0, 2, F_IRQ | F_DS, 0, 16'd10, 32'h300);
        clear_logs();
        do_kick(32'h040);
        grant(1);
        wait_idle();
        eq("R3 word count for 10 bytes", tx_cnt, 3);
        for (int k = 0; k < 3; k++) eq("R3 data to peripheral", tx_log[k], 32'hC0C0_0000 + k);
        eq("R3 memory reads", acc_cnt, 6);
        eq("R3 data address", acc_log[5], 32'h308);
    endtask

    task automatic t_write();
        put(32'h340, 32'h0); put(32'h344, 32'h0); put(32'h348, 32'h5555);
        wdesc(32'h060, 32'h0, 1, F_IRQ | F_DS, 0, 16'd8, 32'h340);
        clear_logs();
        do_kick(32'h060);
        grant(1);
        wait_idle();
        eq("R4 first word written", mem[32'h340 >> 2], 32'hA000_0000);
        eq("R4 second word written", mem[32'h344 >> 2], 32'hA000_0001);
        eq("R4 no write past count", mem[32'h348 >> 2], 32'h5555);
        eq("R4 irq", irq_cnt, 1);
    endtask

    task automatic t_chain();
        wdesc(32'h080, 32'h0A0, 0, F_CH, 0, 16'd0, 32'h0);
        wdesc(32'h0A0, 32'h0, 0, F_IRQ | F_DS, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h080);
        grant(1);
        wait_idle();
        eq("R7 both descriptors fetched", acc_cnt, 6);
        eq("R7 next pointer followed", acc_log[3], 32'h0A0);
        eq("R7 one irq", irq_cnt, 1);
        // gate between chained descriptors
        wdesc(32'h080, 32'h0A0, 0, F_CH | F_IRQ | F_DS, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h080);
        grant(1);
        wait_idle();
        eq("R1 chain waits for semaphore", acc_cnt, 3);
        eq("R1 first irq", irq_cnt, 1);
        grant(1);
        wait_idle();
        eq("R1 chain resumes", acc_cnt, 6);
        eq("R1 resumes at next", acc_log[3], 32'h0A0);
    endtask

    task automatic t_ring();
        wdesc(32'h0C0, 32'h0E0, 0, F_CH | F_IRQ | F_DS, 0, 16'd0, 32'h0);
        wdesc(32'h0E0, 32'h0C0, 0, F_CH | F_IRQ | F_DS, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h0C0);
        grant(3);
        wait_idle();
        eq("R7 ring runs granted count", irq_cnt, 3);
        eq("R7 ring semaphore drained", sem_count, 0);
        clear_logs();
        grant(1);
        wait_idle();
        eq("R7 ring continues in order", acc_log[0], 32'h0E0);
        eq("R7 ring one more period", irq_cnt, 1);
    endtask

    task automatic t_wait_end();
        wdesc(32'h120, 32'h0, 0, F_IRQ | F_DS | F_WE, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h120);
        grant(1);
        repeat (30) @(negedge clk);
        eq("R8 no irq before end", irq_cnt, 0);
        eq("R8 still busy", busy, 1);
        eq("R8 semaphore kept", sem_count, 1);
        per_end = 1'b1;
        @(negedge clk);
        per_end = 1'b0;
        wait_idle();
        eq("R8 irq after end", irq_cnt, 1);
        eq("R8 semaphore taken after end", sem_count, 0);
    endtask

    task automatic t_term();
        // halt on terminate
        wdesc(32'h140, 32'h100, 2, F_CH | F_IRQ | F_DS | F_HT | F_FL, 0, 16'd16, 32'h300);
        clear_logs();
        tx_rdy = 1'b0;
        do_kick(32'h140);
        grant(2);
        repeat (20) @(negedge clk);
        eq("R9 stalled in data phase", busy, 1);
        per_term = 1'b1;
        @(negedge clk);
        per_term = 1'b0;
        wait_idle();
        eq("R9 term_err raised", term_err, 1);
        eq("R9 no irq on halt", irq_cnt, 0);
        eq("R9 semaphore kept on halt", sem_count, 2);
        eq("R9 chain dropped", acc_cnt, 4);
        // terminate without the flush bit is ignored
        wdesc(32'h160, 32'h0, 2, F_IRQ | F_DS | F_HT, 0, 16'd4, 32'h300);
        clear_logs();
        do_kick(32'h160);
        eq("R11 kick clears term_err", term_err, 0);
        repeat (20) @(negedge clk);
        per_term = 1'b1;
        @(negedge clk);
        per_term = 1'b0;
        repeat (5) @(negedge clk);
        eq("R9 terminate ignored without flush", busy, 1);
        tx_rdy = 1'b1;
        wait_idle();
        eq("R9 word sent after ignored terminate", tx_cnt, 1);
        eq("R9 completes normally", irq_cnt, 1);
        // flush without halt
        wdesc(32'h160, 32'h0, 2, F_IRQ | F_DS | F_FL, 0, 16'd16, 32'h300);
        grant(1);
        clear_logs();
        tx_rdy = 1'b0;
        do_kick(32'h160);
        repeat (20) @(negedge clk);
        per_term = 1'b1;
        @(negedge clk);
        per_term = 1'b0;
        wait_idle();
        tx_rdy = 1'b1;
        eq("R9 flush completes with irq", irq_cnt, 1);
        eq("R9 flush no term_err", term_err, 0);
        eq("R9 flush no data sent", tx_cnt, 0);
        eq("R9 flush takes semaphore", sem_count, 1);
    endtask

    task automatic t_errors();
        wdesc(32'h180, 32'h0, 3, F_IRQ | F_DS, 0, 16'd0, 32'h0);
        clear_logs();
        do_kick(32'h180);
        wait_idle();
        eq("R10 code 3 bus_err", bus_err, 1);
        eq("R10 code 3 no irq", irq_cnt, 0);
        eq("R10 code 3 semaphore kept", sem_count, 1);
        wdesc(32'h180, 32'h0, 0, F_IRQ | F_DS, 0, 16'hFF01, 32'h0);
        do_kick(32'h180);
        eq("R11 kick clears bus_err", bus_err, 0);
        wait_idle();
        eq("R10 count above limit", bus_err, 1);
        wdesc(32'h180, 32'h0, 0, F_IRQ | F_DS, 0, 16'hFF00, 32'h0);
        do_kick(32'h180);
        wait_idle();
        eq("R10 count at limit accepted", bus_err, 0);
        eq("R10 count at limit irq", irq_cnt, 1);
        eq("R10 count at limit sem", sem_count, 0);
        err_addr = 32'h304;
        wdesc(32'h1A0, 32'h0, 2, F_IRQ | F_DS, 0, 16'd12, 32'h300);
        clear_logs();
        do_kick(32'h1A0);
        grant(1);
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        eq("R10 mem_err bus_err", bus_err, 1);
        eq("R10 mem_err stops data", tx_cnt, 1);
        eq("R10 mem_err no irq", irq_cnt, 0);
        eq("R10 mem_err semaphore kept", sem_count, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_pio();
        t_read();
        t_write();
        t_chain();
        t_ring();
        t_wait_end();
        t_term();
        t_errors();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule